// File: doc/BRIEF.md
# PLL Reconfiguration and Relock Sequencer

This block reprograms a PLL from a configuration entry supplied alongside a target output rate. On a start request it captures the target and the entry. If the target is above the core threshold (500 MHz), it first moves the companion interface-clock divider to half rate. It then writes a fresh control word with the powerdown and bypass bits cleared, waits a fixed settle window of 100 µs counted in system-clock cycles, and samples the PLL lock and error status. The outcome is reported as a result code.

When the target is at or below the threshold, the interface divider returns to full rate only after a relock that reports neither a timeout nor an error. A failed relock leaves the divider where it was. A readback path decodes the present control word into the effective PLL output rate. Bypass takes priority and yields the reference rate. Powerdown yields zero. Otherwise the rate is reference × 2·(feedback code+1) / ((input code+1) · 2^output code). The reference is 33.33 MHz for the core and system PLLs and 27 MHz for the video PLL, set by parameter.

The sequencer has five states:
- `ST_IDLE`: start leads to `ST_PREP`.
- `ST_PREP`: always leads to `ST_PROG`.
- `ST_PROG`: always leads to `ST_SETTLE`.
- `ST_SETTLE`: leads to `ST_JUDGE` when the settle timer expires.
- `ST_JUDGE`: always leads back to `ST_IDLE`.

Top module: `pll_relock_seq`

## Requirements
- R1: On each start the control word is rebuilt from the captured entry. The fields are:
  - bit 0: powerdown, written as 0.
  - bit 1: bypass, written as 0.
  - bits 3:2: output-divider code.
  - bits 8:4: input-divider code.
  - bits 15:9: feedback-divider code.
  - bits from 20 upward: band.
  - All other bits are written as 0.
- R2: `rate_hz` equals floor(REF_HZ × 2·(fb+1) / ((in+1)·2^out)) for the present control word when neither bypass nor powerdown is set.
- R3: `rate_hz` is REF_HZ whenever bit 1 (bypass) is set, even if bit 0 is also set. It is 0 when only bit 0 (powerdown) is set. The control word resets to parameter `CTRL_RESET`.
- R4: Counting the clock edge that samples `start` as the first, `done` rises at edge WAIT_CYCLES+4, where WAIT_CYCLES = CLK_HZ·WAIT_US/10^6. `busy` is high from the first edge until then.
- R5: If `pll_status[0]` (lock) is 0 when sampled, `result` is 1 (timeout).
- R6: If lock is 1 and `pll_status[1]` (error) is 1, `result` is 2 (error). With lock 1 and error 0, `result` is 0 (success).
- R7: When the target is above THRESH_HZ, `if_div_sel` becomes 1 (divide-by-2) one cycle before the new control word appears.
- R8: When the target is at or below THRESH_HZ, `if_div_sel` becomes 0 only at completion with success. On timeout or error it keeps its value. It never changes before completion.
- R9: A start request while `busy` is high is ignored and leaves the captured configuration unchanged.
- R10: `done` and `result` hold their values until the next start request.
- R11: After reset, `busy`, `done`, `if_div_sel` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reconfiguration (pulse) |
| target_rate | input | 32 | Target PLL rate in Hz |
| cfg_in_div | input | 5 | Input-divider code |
| cfg_fb_div | input | 7 | Feedback-divider code |
| cfg_out_div | input | 2 | Output-divider code |
| cfg_band | input | BAND_W | Band code |
| pll_status | input | 2 | Bit 0 lock, bit 1 error |
| ctrl_word | output | 32 | PLL control word |
| if_div_sel | output | 1 | Interface divider: 0 divide-by-1, 1 divide-by-2 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, result valid |
| result | output | 2 | 0 success, 1 timeout, 2 error |
| rate_hz | output | RATE_W | Decoded effective PLL rate |

## Verification
The bench builds the main instance with CLK_HZ = 1 MHz and WAIT_US = 16. This shrinks the settle window to 16 cycles, so the exact completion edge can be counted. It also lets a PLL model that relocks after 5 cycles succeed, and one that needs 40 cycles time out. A second instance uses a 27 MHz reference and a reset word with both bypass and powerdown set, which brings the bypass-over-powerdown priority within reach. The main instance resets to powerdown only, which exposes the zero-rate case.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_ERROR   = 2'd2
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PREP, ST_PROG, ST_SETTLE, ST_JUDGE
    } st_e;

    localparam int WORD_W   = 32;
    localparam int PD_BIT   = 0;
    localparam int BYP_BIT  = 1;
    localparam int OD_LSB   = 2;
    localparam int OD_W     = 2;
    localparam int ID_LSB   = 4;
    localparam int ID_W     = 5;
    localparam int FB_LSB   = 9;
    localparam int FB_W     = 7;
    localparam int BAND_LSB = 20;
endpackage

// File: rtl/pll_word_pack.sv
module pll_word_pack
    import pll_seq_pkg::*;
#(
    parameter int BAND_W = 2
) (
    input  logic [ID_W-1:0]   in_div,
    input  logic [FB_W-1:0]   fb_div,
    input  logic [OD_W-1:0]   out_div,
    input  logic [BAND_W-1:0] band,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = '0;
        word[OD_LSB +: OD_W]       = out_div;
        word[ID_LSB +: ID_W]       = in_div;
        word[FB_LSB +: FB_W]       = fb_div;
        word[BAND_LSB +: BAND_W]   = band;
    end
endmodule

// File: rtl/pll_rate_decode.sv
module pll_rate_decode
    import pll_seq_pkg::*;
#(
    parameter int REF_HZ = 33333333,
    parameter int RATE_W = 34
) (
    input  logic [WORD_W-1:0] word,
    output logic [RATE_W-1:0] rate_hz
);
    localparam int PROD_W = RATE_W + 9;

    logic [ID_W:0]     in_eff;
    logic [FB_W+1:0]   fb_eff;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        in_eff = {1'b0, word[ID_LSB +: ID_W]} + 1'b1;
        fb_eff = ({2'b00, word[FB_LSB +: FB_W]} + 1'b1) << 1;
        prod   = PROD_W'(REF_HZ) * PROD_W'(fb_eff);
        quot   = (prod >> word[OD_LSB +: OD_W]) / PROD_W'(in_eff);
        if (word[BYP_BIT])
            rate_hz = RATE_W'(REF_HZ);
        else if (word[PD_BIT])
            rate_hz = '0;
        else
            rate_hz = quot[RATE_W-1:0];
    end
endmodule

// File: rtl/pll_settle_timer.sv
module pll_settle_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(CYCLES - 1));
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq
    import pll_seq_pkg::*;
#(
    parameter int          CLK_HZ     = 100_000_000,
    parameter int          WAIT_US    = 100,
    parameter int          REF_HZ     = 33333333,
    parameter int          THRESH_HZ  = 500_000_000,
    parameter int          BAND_W     = 2,
    parameter int          RATE_W     = 34,
    parameter logic [31:0] CTRL_RESET = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       target_rate,
    input  logic [4:0]        cfg_in_div,
    input  logic [6:0]        cfg_fb_div,
    input  logic [1:0]        cfg_out_div,
    input  logic [BAND_W-1:0] cfg_band,
    input  logic [1:0]        pll_status,
    output logic [31:0]       ctrl_word,
    output logic              if_div_sel,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [RATE_W-1:0] rate_hz
);
    localparam longint WAIT_RAW    = (longint'(CLK_HZ) * WAIT_US) / 1_000_000;
    localparam int     WAIT_CYCLES = (WAIT_RAW < 1) ? 1 : int'(WAIT_RAW);

    st_e state, state_nx;

    logic [ID_W-1:0]   in_q;
    logic [FB_W-1:0]   fb_q;
    logic [OD_W-1:0]   od_q;
    logic [BAND_W-1:0] band_q;
    logic              above_q;
    logic [31:0]       packed_word;
    logic              settle_done;

    pll_word_pack #(.BAND_W(BAND_W)) u_pack (
        .in_div (in_q),
        .fb_div (fb_q),
        .out_div(od_q),
        .band   (band_q),
        .word   (packed_word)
    );

    pll_settle_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state == ST_PROG),
        .run    (state == ST_SETTLE),
        .expired(settle_done)
    );

    pll_rate_decode #(.REF_HZ(REF_HZ), .RATE_W(RATE_W)) u_decode (
        .word   (ctrl_word),
        .rate_hz(rate_hz)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_PREP;
            ST_PREP:   state_nx = ST_PROG;
            ST_PROG:   state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_nx = ST_JUDGE;
            ST_JUDGE:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word  <= CTRL_RESET;
            if_div_sel <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            result     <= RES_OK;
            in_q       <= '0;
            fb_q       <= '0;
            od_q       <= '0;
            band_q     <= '0;
            above_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    in_q    <= cfg_in_div;
                    fb_q    <= cfg_fb_div;
                    od_q    <= cfg_out_div;
                    band_q  <= cfg_band;
                    above_q <= (target_rate > 32'(THRESH_HZ));
                    busy    <= 1'b1;
                    done    <= 1'b0;
                end
                ST_PREP:   if (above_q) if_div_sel <= 1'b1;
                ST_PROG:   ctrl_word <= packed_word;
                ST_SETTLE: ;
                ST_JUDGE: begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (!pll_status[0])
                        result <= RES_TIMEOUT;
                    else if (pll_status[1])
                        result <= RES_ERROR;
                    else begin
                        result <= RES_OK;
                        if (!above_q) if_div_sel <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pll_relock_seq_chk.sv
module pll_relock_seq_chk #(
    parameter int THRESH_HZ = 500_000_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] ctrl_word,
    input logic        if_div_sel,
    input logic        busy,
    input logic        done,
    input logic [1:0]  result,
    input logic        above_q
);
    p_div2_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ctrl_word) && above_q) |-> $past(if_div_sel));

    p_clean_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word) |-> (ctrl_word[1:0] == 2'b00));

    p_div1_on_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(if_div_sel) |-> (done && result == 2'd0 && !above_q));

    p_done_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));

    p_busy_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

bind pll_relock_seq pll_relock_seq_chk #(.THRESH_HZ(THRESH_HZ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ctrl_word (ctrl_word),
    .if_div_sel(if_div_sel),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .above_q   (above_q)
);

// File: tb/pll_relock_seq_bench.sv
module pll_relock_seq_bench;
    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target_rate = '0;
    logic [4:0]  cfg_in_div = '0;
    logic [6:0]  cfg_fb_div = '0;
    logic [1:0]  cfg_out_div = '0;
    logic [1:0]  cfg_band = '0;
    logic        lock = 1'b0;
    logic        err_force = 1'b0;
    logic [1:0]  pll_status;
    logic [31:0] ctrl_word, ctrl_word_b;
    logic        if_div_sel, busy, done, sel_b, busy_b, done_b;
    logic [1:0]  result, result_b;
    logic [33:0] rate_hz, rate_b;

    int checks = 0, fails = 0, lock_delay = 5, lock_cnt = 0, cyc = 0;
    logic [31:0] last_word = '0;

    assign pll_status = {err_force, lock};

    always #5 clk = ~clk;

    pll_relock_seq #(.CLK_HZ(1_000_000), .WAIT_US(W)) u_pll_relock_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .target_rate(target_rate),
        .cfg_in_div(cfg_in_div), .cfg_fb_div(cfg_fb_div), .cfg_out_div(cfg_out_div),
        .cfg_band(cfg_band), .pll_status(pll_status), .ctrl_word(ctrl_word),
        .if_div_sel(if_div_sel), .busy(busy), .done(done), .result(result),
        .rate_hz(rate_hz));

    pll_relock_seq #(.CLK_HZ(1_000_000), .WAIT_US(W), .REF_HZ(27_000_000),
                     .CTRL_RESET(32'h0000_0003)) u_pll_relock_seq_byp (
        .clk(clk), .rst_n(rst_n), .start(1'b0), .target_rate(target_rate),
        .cfg_in_div(cfg_in_div), .cfg_fb_div(cfg_fb_div), .cfg_out_div(cfg_out_div),
        .cfg_band(cfg_band), .pll_status(2'b01), .ctrl_word(ctrl_word_b),
        .if_div_sel(sel_b), .busy(busy_b), .done(done_b), .result(result_b),
        .rate_hz(rate_b));

    // PLL model: loses lock on every control-word change, relocks after lock_delay cycles
    always @(posedge clk) begin
        if (ctrl_word != last_word) begin
            last_word <= ctrl_word;
            lock_cnt  <= 0;
            lock      <= 1'b0;
        end else if (lock_cnt >= lock_delay) begin
            lock <= 1'b1;
        end else begin
            lock_cnt <= lock_cnt + 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected < 100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    int          lat;
    logic        sel_at2, sel_pre_judge;
    logic [31:0] word_at2;

    // Issue a request and run to completion, recording intermediate observations
    task automatic run_req(input logic [31:0] tgt, input logic [4:0] id, input logic [6:0] fb,
                           input logic [1:0] od, input logic [1:0] bd, input bit poke);
        @(negedge clk);
        target_rate = tgt; cfg_in_div = id; cfg_fb_div = fb; cfg_out_div = od; cfg_band = bd;
        start = 1'b1;
        lat = 0;
        for (int k = 0; k < 1000; k++) begin
            @(posedge clk);
            lat = lat + 1;
            @(negedge clk);
            if (lat == 1) start = 1'b0;
            if (lat == 2) begin sel_at2 = if_div_sel; word_at2 = ctrl_word; end
            if (poke && lat == 5) begin
                start = 1'b1; cfg_fb_div = 7'd5; cfg_in_div = 5'd3; target_rate = 32'd100;
            end
            if (poke && lat == 6) start = 1'b0;
            if (lat == W + 3) sel_pre_judge = if_div_sel;
            if (done) break;
        end
        if (!done) chk("R4 done never rose", 0, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 busy after reset", busy, 0);
        chk("R11 done after reset", done, 0);
        chk("R11 if_div_sel after reset", if_div_sel, 0);
        chk("R11 result after reset", result, 0);
        chk("R3 reset word", ctrl_word, 32'h1);
        chk("R3 powerdown rate", rate_hz, 0);
        chk("R3 bypass beats powerdown", rate_b, 27_000_000);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_raise_800();
        lock_delay = 5; err_force = 1'b0;
        run_req(32'd800_000_000, 5'd0, 7'd23, 2'd1, 2'd1, 1'b0);
        chk("R4 latency", lat, W + 4);
        chk("R7 div2 selected before word", sel_at2, 1);
        chk("R7 word still old at div2 switch", word_at2, 32'h1);
        chk("R1 word 800M", ctrl_word, 32'h0010_2E04);
        chk("R2 rate 800M", rate_hz, 64'd799_999_992);
        chk("R6 success result", result, 0);
        chk("R7 sel after raise", if_div_sel, 1);
    endtask

    task automatic t_lower_timeout();
        lock_delay = 40; err_force = 1'b0;
        run_req(32'd400_000_000, 5'd1, 7'd47, 2'd2, 2'd0, 1'b0);
        chk("R5 timeout result", result, 1);
        chk("R8 sel kept on timeout", if_div_sel, 1);
        chk("R1 word 400M", ctrl_word, 32'h0000_5E18);
        chk("R2 rate 400M", rate_hz, 64'd399_999_996);
    endtask

    task automatic t_lower_error();
        lock_delay = 5; err_force = 1'b1;
        run_req(32'd400_000_000, 5'd1, 7'd47, 2'd2, 2'd0, 1'b0);
        chk("R6 error result", result, 2);
        chk("R8 sel kept on error", if_div_sel, 1);
        err_force = 1'b0;
    endtask

    task automatic t_lower_ok();
        lock_delay = 5; err_force = 1'b0;
        run_req(32'd400_000_000, 5'd1, 7'd47, 2'd2, 2'd0, 1'b0);
        chk("R8 sel held until completion", sel_pre_judge, 1);
        chk("R8 sel returns to div1", if_div_sel, 0);
        chk("R6 ok result", result, 0);
    endtask

    task automatic t_at_threshold();
        run_req(32'd500_000_000, 5'd0, 7'd14, 2'd1, 2'd0, 1'b0);
        chk("R7 no div2 at threshold", sel_at2, 0);
        chk("R8 sel at threshold", if_div_sel, 0);
        chk("R2 rate 500M", rate_hz, 64'd499_999_995);
    endtask

    task automatic t_max_and_poke();
        run_req(32'd1_600_000_000, 5'd1, 7'd47, 2'd0, 2'd3, 1'b1);
        chk("R9 start while busy ignored (word)", ctrl_word, 32'h0030_5E10);
        chk("R9 latency unchanged by poke", lat, W + 4);
        chk("R2 rate 1.6G", rate_hz, 64'd1_599_999_984);
        chk("R7 sel at 1.6G", if_div_sel, 1);
    endtask

    task automatic t_hold();
        repeat (10) @(negedge clk);
        chk("R10 done held", done, 1);
        chk("R10 result held", result, 0);
        chk("R10 busy low while idle", busy, 0);
    endtask

    initial begin
        t_reset();
        t_raise_800();
        t_lower_timeout();
        t_lower_error();
        t_lower_ok();
        t_at_threshold();
        t_max_and_poke();
        t_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule